// File: doc/BRIEF.md
# APB3 to Register Strobe Bridge

This block sits between an APB3 slave port and the register logic of a peripheral. It turns each APB access into one internal request pulse. The pulse carries a write flag, a byte address counted from the block's own base, the write data, and a per-bit write enable vector. The block then waits for the register side to answer with a read or a write acknowledge pulse. That answer completes the APB transfer in the same cycle: PREADY rises, and PSLVERR and PRDATA take their values from the acknowledge.

Reads and writes share the one request strobe, so the downstream address decode can be shared by both directions. Read and write acknowledges are separate strobes. The register side may therefore answer after any fixed number of cycles, including zero. Because only one transfer is ever open, no back-pressure path is needed. Parameters set the APB address width, the data width, the width of the internal address window and the base address. The base address decides at elaboration which address-relativisation variant is built: a plain bit slice when the base is aligned to the window, or a subtraction when it is not.

Top module: `apb_strobe_bridge`

## Requirements
- R1: `req` is high for exactly one cycle per transfer: the first cycle in which `psel` and `penable` are both high while no transfer is open. It is never high in the APB setup phase (`psel` high, `penable` low).
- R2: While a transfer is open and waiting for its acknowledge, `req` stays low, even though `psel` and `penable` stay high.
- R3: While `req` is high, `req_wr` equals `pwrite`, `req_wdata` equals `pwdata`, every bit of `req_biten` is 1, and `req_addr` equals `(paddr - BASE_ADDR)` truncated to SPAN_W bits (with the default base 0x4000_0000 and SPAN_W=12, this is `paddr[11:0]`).
- R4: `pready` is high in exactly the cycle in which the acknowledge of the open transfer's direction arrives: `rd_ack` for a read, `wr_ack` for a write. This includes an acknowledge that arrives in the same cycle as `req`.
- R5: An acknowledge of the opposite direction (`rd_ack` during a write, `wr_ack` during a read) does not complete the transfer. `pready` stays low and the transfer stays open.
- R6: `pslverr` equals `rd_err` on a completing read and `wr_err` on a completing write. It is 0 in every cycle where `pready` is low.
- R7: `prdata` equals `rd_data` in the completing cycle of a read. It is all zeros in every other cycle, including write completions.
- R8: Asserting `rst_n` low closes any open transfer. After release, the next access phase produces a new `req` in its first cycle.
- R9: Acknowledge pulses that arrive while no access phase is present (`psel` low) produce neither `pready` nor `req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB transfer complete |
| pslverr | output | 1 | APB slave error |
| req | output | 1 | Internal request pulse |
| req_wr | output | 1 | Request is a write |
| req_addr | output | SPAN_W | Base-relative byte address |
| req_wdata | output | DATA_W | Write data |
| req_biten | output | DATA_W | Per-bit write enables |
| rd_ack | input | 1 | Read acknowledge pulse |
| rd_data | input | DATA_W | Read data, valid with `rd_ack` |
| rd_err | input | 1 | Read error, valid with `rd_ack` |
| wr_ack | input | 1 | Write acknowledge pulse |
| wr_err | input | 1 | Write error, valid with `wr_ack` |

## Verification
The only state in the block is the open-transfer flag and the direction latched with it, so a corrupted flag appears at the ports within one cycle. If the flag is falsely clear, `req` fires a second time during a long wait. If it is falsely set, the next access phase starts with no `req` and hangs. A wrong latched direction makes the transfer complete on the wrong acknowledge, or not at all. This shows as `pready` in the cycle of the mismatched pulse, or as a missing `pready` in the cycle of the correct one. The bench therefore varies acknowledge latency from zero to three cycles and sends mismatched and stray pulses.

// File: rtl/bsb_pkg.sv
package bsb_pkg;

   typedef enum logic {
      BSB_IDLE = 1'b0,
      BSB_WAIT = 1'b1
   } bsb_state_e;

   function automatic bit bsb_width_ok(input int w);
      return (w == 8) || (w == 16) || (w == 32) || (w == 64);
   endfunction

endpackage

// File: rtl/bsb_track.sv
module bsb_track
   import bsb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic access,
   input  logic pwrite,
   input  logic rd_ack,
   input  logic wr_ack,
   output logic launch,
   output logic done,
   output logic dir_wr
);

   bsb_state_e state_q;
   logic       wr_q;
   logic       busy;
   logic       hit;

   assign busy   = (state_q == BSB_WAIT);
   assign launch = access & ~busy;
   assign dir_wr = busy ? wr_q : pwrite;
   assign hit    = dir_wr ? wr_ack : rd_ack;
   assign done   = access & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BSB_IDLE;
         wr_q    <= 1'b0;
      end else begin
         if (launch && !done) begin
            state_q <= BSB_WAIT;
            wr_q    <= pwrite;
         end else if (busy && done) begin
            state_q <= BSB_IDLE;
         end
      end
   end

endmodule

// File: rtl/bsb_addr_rel.sv
module bsb_addr_rel #(
   parameter int                 ADDR_W    = 32,
   parameter int                 SPAN_W    = 12,
   parameter logic [ADDR_W-1:0]  BASE_ADDR = '0
) (
   input  logic [ADDR_W-1:0] paddr,
   output logic [SPAN_W-1:0] rel_addr
);

   localparam bit BASE_ALIGNED = (BASE_ADDR[SPAN_W-1:0] == '0);

   generate
      if (BASE_ALIGNED) begin : g_slice
         logic unused_hi;
         assign unused_hi = ^paddr[ADDR_W-1:SPAN_W];
         assign rel_addr  = paddr[SPAN_W-1:0];
      end else begin : g_sub
         logic [ADDR_W-1:0] diff;
         logic              unused_hi;
         assign diff      = paddr - BASE_ADDR;
         assign unused_hi = ^diff[ADDR_W-1:SPAN_W];
         assign rel_addr  = diff[SPAN_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/bsb_resp.sv
module bsb_resp #(
   parameter int DATA_W = 32
) (
   input  logic              done,
   input  logic              dir_wr,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_err,
   input  logic              wr_err,
   output logic              pready,
   output logic              pslverr,
   output logic [DATA_W-1:0] prdata
);

   always_comb begin
      pready  = done;
      pslverr = done & (dir_wr ? wr_err : rd_err);
      prdata  = (done && !dir_wr) ? rd_data : '0;
   end

endmodule

// File: rtl/apb_strobe_bridge.sv
module apb_strobe_bridge
   import bsb_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                DATA_W    = 32,
   parameter int                SPAN_W    = 12,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   output logic              req,
   output logic              req_wr,
   output logic [SPAN_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] req_biten,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_err,
   input  logic              wr_ack,
   input  logic              wr_err
);

   generate
      if (!bsb_width_ok(DATA_W)) begin : g_bad_data_w
         $error("apb_strobe_bridge: DATA_W must be 8, 16, 32 or 64");
      end
      if (SPAN_W < 2 || SPAN_W >= ADDR_W) begin : g_bad_span_w
         $error("apb_strobe_bridge: SPAN_W must lie in [2, ADDR_W-1]");
      end
   endgenerate

   logic access;
   logic launch;
   logic done;
   logic dir_wr;

   assign access = psel & penable;

   bsb_track u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .access (access),
      .pwrite (pwrite),
      .rd_ack (rd_ack),
      .wr_ack (wr_ack),
      .launch (launch),
      .done   (done),
      .dir_wr (dir_wr)
   );

   bsb_addr_rel #(
      .ADDR_W    (ADDR_W),
      .SPAN_W    (SPAN_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_addr (
      .paddr    (paddr),
      .rel_addr (req_addr)
   );

   bsb_resp #(
      .DATA_W (DATA_W)
   ) u_resp (
      .done    (done),
      .dir_wr  (dir_wr),
      .rd_data (rd_data),
      .rd_err  (rd_err),
      .wr_err  (wr_err),
      .pready  (pready),
      .pslverr (pslverr),
      .prdata  (prdata)
   );

   assign req       = launch;
   assign req_wr    = pwrite;
   assign req_wdata = pwdata;
   assign req_biten = '1;

endmodule

// File: rtl/apb_strobe_bridge_chk.sv
module apb_strobe_bridge_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pready,
   input logic              pslverr,
   input logic [DATA_W-1:0] prdata,
   input logic              req,
   input logic [DATA_W-1:0] req_biten,
   input logic              rd_ack,
   input logic              wr_ack
);

   // R1: a request only appears in an access phase
   a_r1_req_in_access: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (psel && penable));

   // R2: a request is never repeated in the following cycle
   a_r2_single_req: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> !req);

   // R3: full-width writes only
   a_r3_biten_full: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (&req_biten));

   // R4: completion needs an acknowledge pulse
   a_r4_ready_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
      pready |-> (rd_ack || wr_ack));

   // R6: error only in a completing cycle
   a_r6_err_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
      pslverr |-> pready);

   // R7: read data is zero outside completion
   a_r7_prdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !pready |-> (prdata == '0));

   // R9: no completion without an access phase
   a_r9_no_stray_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !psel |-> (!pready && !req));

endmodule

bind apb_strobe_bridge apb_strobe_bridge_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .psel      (psel),
   .penable   (penable),
   .pready    (pready),
   .pslverr   (pslverr),
   .prdata    (prdata),
   .req       (req),
   .req_biten (req_biten),
   .rd_ack    (rd_ack),
   .wr_ack    (wr_ack)
);

// File: tb/apb_strobe_bridge_tb.sv
module apb_strobe_bridge_tb;

   localparam logic [31:0] BASE = 32'h4000_0000;

   typedef struct packed {
      logic        wr;
      logic [31:0] paddr;
      logic [31:0] wdata;
      logic [1:0]  lat;
      logic        err;
      logic [31:0] rdata;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{1'b1, 32'h4000_001C, 32'hDEAD_BEEF, 2'd0, 1'b0, 32'h0000_0000},
      '{1'b0, 32'h4000_0FFC, 32'h0000_0000, 2'd2, 1'b0, 32'h1234_5678},
      '{1'b1, 32'h4000_0000, 32'hA5A5_5A5A, 2'd3, 1'b1, 32'h0000_0000},
      '{1'b0, 32'h4000_0004, 32'h0000_0000, 2'd0, 1'b1, 32'hCAFE_F00D},
      '{1'b0, 32'h4000_0800, 32'h0000_0000, 2'd1, 1'b0, 32'hFFFF_FFFF},
      '{1'b1, 32'h4000_0ABC, 32'h0000_0001, 2'd1, 1'b0, 32'h0000_0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [31:0] paddr = '0, pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr;
   logic        req, req_wr;
   logic [11:0] req_addr;
   logic [31:0] req_wdata, req_biten;
   logic        rd_ack = 1'b0, rd_err = 1'b0, wr_ack = 1'b0, wr_err = 1'b0;
   logic [31:0] rd_data = '0;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   apb_strobe_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .req(req), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_biten(req_biten),
      .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
      .wr_ack(wr_ack), .wr_err(wr_err)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic clear_ack();
      rd_ack = 1'b0; wr_ack = 1'b0; rd_err = 1'b0; wr_err = 1'b0; rd_data = '0;
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] rel;
      // R8: reset state
      repeat (3) @(negedge clk);
      #2;
      chk("R8 reset req", {31'b0, req}, 32'd0);
      chk("R8 reset pready", {31'b0, pready}, 32'd0);
      @(negedge clk) rst_n = 1'b1;

      // Table walk: R1 R2 R3 R4 R6 R7
      for (int v = 0; v < 6; v++) begin
         @(negedge clk);
         psel = 1'b1; penable = 1'b0; pwrite = VEC[v].wr;
         paddr = VEC[v].paddr; pwdata = VEC[v].wdata;
         #2 chk("R1 no req in setup", {31'b0, req}, 32'd0);
         @(negedge clk);
         penable = 1'b1;
         for (int k = 0; k <= int'(VEC[v].lat); k++) begin
            if (k == int'(VEC[v].lat)) begin
               if (VEC[v].wr) begin
                  wr_ack = 1'b1; wr_err = VEC[v].err;
               end else begin
                  rd_ack = 1'b1; rd_err = VEC[v].err; rd_data = VEC[v].rdata;
               end
            end
            #2;
            if (k == 0) begin
               chk("R1 req in first access cycle", {31'b0, req}, 32'd1);
               rel = VEC[v].paddr - BASE;
               chk("R3 req_addr", {20'b0, req_addr}, {20'b0, rel[11:0]});
               chk("R3 req_wr", {31'b0, req_wr}, {31'b0, VEC[v].wr});
               chk("R3 req_biten", req_biten, 32'hFFFF_FFFF);
               if (VEC[v].wr) chk("R3 req_wdata", req_wdata, VEC[v].wdata);
            end else begin
               chk("R2 no repeat req", {31'b0, req}, 32'd0);
            end
            if (k == int'(VEC[v].lat)) begin
               chk("R4 pready on ack", {31'b0, pready}, 32'd1);
               chk("R6 pslverr", {31'b0, pslverr}, {31'b0, VEC[v].err});
               chk("R7 prdata", prdata, VEC[v].wr ? 32'd0 : VEC[v].rdata);
            end else begin
               chk("R4 no pready before ack", {31'b0, pready}, 32'd0);
               chk("R6 no pslverr before ack", {31'b0, pslverr}, 32'd0);
            end
            @(negedge clk);
            clear_ack();
         end
         psel = 1'b0; penable = 1'b0;
      end

      // R5: opposite-direction acknowledge is ignored during a write
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = BASE + 32'h10; pwdata = 32'h5;
      @(negedge clk) penable = 1'b1;
      @(negedge clk);
      rd_ack = 1'b1; rd_err = 1'b1; rd_data = 32'h7777_7777;
      #2;
      chk("R5 rd_ack ignored in write", {31'b0, pready}, 32'd0);
      chk("R5 no pslverr", {31'b0, pslverr}, 32'd0);
      chk("R7 prdata zero when not ready", prdata, 32'd0);
      @(negedge clk);
      clear_ack();
      wr_ack = 1'b1;
      #2 chk("R5 write still open, completes on wr_ack", {31'b0, pready}, 32'd1);
      @(negedge clk);
      clear_ack(); psel = 1'b0; penable = 1'b0;

      // R9: stray acknowledges with no access phase
      @(negedge clk);
      rd_ack = 1'b1; wr_ack = 1'b1; rd_err = 1'b1; rd_data = 32'h1;
      #2;
      chk("R9 stray ack pready", {31'b0, pready}, 32'd0);
      chk("R9 stray ack req", {31'b0, req}, 32'd0);
      @(negedge clk) clear_ack();

      // R8: reset closes an open read
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = BASE + 32'h20;
      @(negedge clk) penable = 1'b1;
      @(negedge clk);
      #2 chk("R2 open read no req", {31'b0, req}, 32'd0);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; paddr = BASE + 32'h24;
      @(negedge clk) penable = 1'b1;
      #2 chk("R8 new req after reset", {31'b0, req}, 32'd1);
      @(negedge clk);
      rd_ack = 1'b1; rd_data = 32'h0BAD_F00D;
      #2 chk("R8 read after reset completes", prdata, 32'h0BAD_F00D);
      @(negedge clk);
      clear_ack(); psel = 1'b0; penable = 1'b0;

      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule